// File: doc/BRIEF.md
# BCD to Seven-Segment Decoder with Blanking

This block turns packed BCD digits into active-low seven-segment drives. Each digit stage has three active-low controls. Lamp test lights every segment. A blanking input darkens the digit. A ripple-blanking input darkens the digit when it holds a zero that carries no value. The ripple-blanking input and output are separate pins, so stages can be chained.

The top module chains `NUM_DIGITS` stages, four by default. The most significant stage always has ripple blanking requested. Each stage passes its ripple-blanking output down to the next lower stage. The least significant stage never blanks by ripple, so a value of zero still shows a single `0`. Together these rules suppress leading zeros and leave inner and trailing zeros visible. Lamp test is shared by all stages. Each stage has its own blanking input. The block is purely combinational.

Top module: `seg7_blank_chain`

## Requirements
- R1: With all controls inactive (high) and no ripple blanking in effect, codes 0 to 9 drive the standard glyphs. `seg_no` bit 0 is segment a and bit 6 is segment g, and a 0 bit lights a segment. The active-low values for codes 0 to 9 are 40,79,24,30,19,12,02,78,00,10 (hex).
- R2: Codes 10 to 15 turn all seven segments off (7F).
- R3: When `lt_ni` is low and a digit's blanking input is high, that digit shows all segments on (00), whatever its code and ripple state.
- R4: When a digit's `bi_ni` bit is low, that digit shows all segments off (7F), overriding both its code and lamp test.
- R5: When a stage's ripple-blanking input is low, its code is 0 and `lt_ni` is high, the stage is dark and its `rbo_no` bit is low.
- R6: In every other case a stage's `rbo_no` bit is high. This includes a zero code during lamp test and a nonzero code with ripple blanking requested.
- R7: A nonzero code on a stage whose ripple-blanking input is low still shows its glyph.
- R8: In the chain, stage k (digit k is `bcd_i[4k+3:4k]`, stage NUM_DIGITS-1 most significant) blanks by ripple exactly when it and every stage above it hold 0. A zero below a nonzero digit is shown.
- R9: The least significant stage never blanks by ripple: `rbo_no[0]` stays high and an all-zero value shows one `0`.
- R10: The `bi_ni` bits act per digit. Blanking one stage does not change the glyph of another stage, and it does not change the ripple chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bcd_i | input | 4*NUM_DIGITS | Packed BCD digits, digit k at bits 4k+3:4k |
| lt_ni | input | 1 | Lamp test, active low, shared |
| bi_ni | input | NUM_DIGITS | Per-digit blanking input, active low |
| seg_no | output | 7*NUM_DIGITS | Active-low segments, digit k at bits 7k+6:7k, a at the low bit |
| rbo_no | output | NUM_DIGITS | Per-stage ripple-blanking output, active low |

## Verification
The block holds no state, so a wrong internal value shows at the ports in the same evaluation as the input that caused it. A wrong glyph entry appears only when the bench drives that code. A fault in the control priority appears only when two controls are asserted together. A broken ripple link shows up as a zero that stays lit or goes dark, one or more places below the fault. The directed patterns therefore include runs of leading zeros of every length, inner zeros, and overlaps of lamp test with blanking.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int unsigned BCD_W = 4;
  localparam int unsigned SEG_W = 7;
  localparam logic [SEG_W-1:0] SEG_DARK_N = '1;
  localparam logic [SEG_W-1:0] SEG_LIT_N  = '0;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  typedef enum logic [1:0] {
    SRC_GLYPH = 2'd0,
    SRC_LAMP  = 2'd1,
    SRC_DARK  = 2'd2
  } seg_src_e;
endpackage

// File: rtl/seg7_glyph.sv
module seg7_glyph
  import seg7_pkg::*;
(
  input  bcd_t code_i,
  output seg_t glyph_o   // active high, bit0 = a
);
  always_comb begin
    unique case (code_i)
      4'd0:    glyph_o = 7'b0111111;
      4'd1:    glyph_o = 7'b0000110;
      4'd2:    glyph_o = 7'b1011011;
      4'd3:    glyph_o = 7'b1001111;
      4'd4:    glyph_o = 7'b1100110;
      4'd5:    glyph_o = 7'b1101101;
      4'd6:    glyph_o = 7'b1111101;
      4'd7:    glyph_o = 7'b0000111;
      4'd8:    glyph_o = 7'b1111111;
      4'd9:    glyph_o = 7'b1101111;
      default: glyph_o = 7'b0000000;  // non-BCD codes stay dark
    endcase
  end
endmodule

// File: rtl/seg7_blank_ctl.sv
module seg7_blank_ctl
  import seg7_pkg::*;
(
  input  logic     is_zero_i,
  input  logic     lt_ni,
  input  logic     rbi_ni,
  input  logic     bi_ni,
  output seg_src_e src_o,
  output logic     rbo_no
);
  logic rip_blank;

  assign rip_blank = !rbi_ni && is_zero_i && lt_ni;
  assign rbo_no    = !rip_blank;

  // priority: blank input > lamp test > ripple blank > glyph
  always_comb begin
    if (!bi_ni)         src_o = SRC_DARK;
    else if (!lt_ni)    src_o = SRC_LAMP;
    else if (rip_blank) src_o = SRC_DARK;
    else                src_o = SRC_GLYPH;
  end
endmodule

// File: rtl/seg7_digit.sv
module seg7_digit
  import seg7_pkg::*;
(
  input  bcd_t code_i,
  input  logic lt_ni,
  input  logic rbi_ni,
  input  logic bi_ni,
  output seg_t seg_no,
  output logic rbo_no
);
  seg_t     glyph;
  seg_src_e src;

  seg7_glyph i_glyph (
    .code_i  (code_i),
    .glyph_o (glyph)
  );

  seg7_blank_ctl i_ctl (
    .is_zero_i (code_i == '0),
    .lt_ni     (lt_ni),
    .rbi_ni    (rbi_ni),
    .bi_ni     (bi_ni),
    .src_o     (src),
    .rbo_no    (rbo_no)
  );

  always_comb begin
    unique case (src)
      SRC_LAMP:  seg_no = SEG_LIT_N;
      SRC_DARK:  seg_no = SEG_DARK_N;
      default:   seg_no = ~glyph;
    endcase
  end
endmodule

// File: rtl/seg7_blank_chain.sv
module seg7_blank_chain
  import seg7_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4
) (
  input  logic [NUM_DIGITS*BCD_W-1:0] bcd_i,
  input  logic                        lt_ni,
  input  logic [NUM_DIGITS-1:0]       bi_ni,
  output logic [NUM_DIGITS*SEG_W-1:0] seg_no,
  output logic [NUM_DIGITS-1:0]       rbo_no
);
  localparam int unsigned MSD = NUM_DIGITS - 1;

  logic [NUM_DIGITS-1:0] rbi_n;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dig
    if (k == 0) begin : g_lsd
      assign rbi_n[k] = 1'b1;        // last digit always shows
    end else if (k == MSD) begin : g_msd
      assign rbi_n[k] = 1'b0;        // top digit starts suppression
    end else begin : g_mid
      assign rbi_n[k] = rbo_no[k+1];
    end

    seg7_digit i_digit (
      .code_i (bcd_i[k*BCD_W +: BCD_W]),
      .lt_ni  (lt_ni),
      .rbi_ni (rbi_n[k]),
      .bi_ni  (bi_ni[k]),
      .seg_no (seg_no[k*SEG_W +: SEG_W]),
      .rbo_no (rbo_no[k])
    );
  end
endmodule

// File: rtl/seg7_blank_chain_chk.sv
module seg7_blank_chain_chk
  import seg7_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4
) (
  input logic [NUM_DIGITS*BCD_W-1:0] bcd_i,
  input logic                        lt_ni,
  input logic [NUM_DIGITS-1:0]       bi_ni,
  input logic [NUM_DIGITS*SEG_W-1:0] seg_no,
  input logic [NUM_DIGITS-1:0]       rbo_no
);
  always_comb begin
    // R9
    lsd_rbo_high_chk: assert (rbo_no[0] === 1'b1);
    for (int k = 0; k < NUM_DIGITS; k++) begin
      // R4
      blank_in_chk: assert (bi_ni[k] || seg_no[k*SEG_W +: SEG_W] == SEG_DARK_N);
      // R3
      lamp_test_chk: assert (!bi_ni[k] || lt_ni || seg_no[k*SEG_W +: SEG_W] == SEG_LIT_N);
      // R2
      non_bcd_dark_chk: assert (bcd_i[k*BCD_W +: BCD_W] < 4'd10 || !lt_ni
                                || seg_no[k*SEG_W +: SEG_W] == SEG_DARK_N);
      // R5
      rbo_dark_chk: assert (rbo_no[k] || (seg_no[k*SEG_W +: SEG_W] == SEG_DARK_N
                            && bcd_i[k*BCD_W +: BCD_W] == '0 && lt_ni));
      // R8
      rbo_chain_chk: assert (rbo_no[k] || k == NUM_DIGITS-1 || !rbo_no[(k+1) % NUM_DIGITS]);
    end
  end
endmodule

bind seg7_blank_chain seg7_blank_chain_chk #(.NUM_DIGITS(NUM_DIGITS)) i_chk (
  .bcd_i  (bcd_i),
  .lt_ni  (lt_ni),
  .bi_ni  (bi_ni),
  .seg_no (seg_no),
  .rbo_no (rbo_no)
);

// File: tb/test_seg7_blank_chain.sv
module test_seg7_blank_chain;
  localparam int N = 4;

  logic          clk = 1'b0;
  logic [4*N-1:0] bcd;
  logic          lt_n;
  logic [N-1:0]  bi_n;
  logic [7*N-1:0] seg_n;
  logic [N-1:0]  rbo_n;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  seg7_blank_chain #(.NUM_DIGITS(N)) i_seg7_blank_chain (
    .bcd_i (bcd), .lt_ni (lt_n), .bi_ni (bi_n), .seg_no (seg_n), .rbo_no (rbo_n)
  );

  function automatic logic [6:0] glyph_n(input logic [3:0] d);
    case (d)
      4'd0: return 7'h40; 4'd1: return 7'h79; 4'd2: return 7'h24; 4'd3: return 7'h30;
      4'd4: return 7'h19; 4'd5: return 7'h12; 4'd6: return 7'h02; 4'd7: return 7'h78;
      4'd8: return 7'h00; 4'd9: return 7'h10;
      default: return 7'h7F;
    endcase
  endfunction

  task automatic drive(input logic [4*N-1:0] b, input logic lt, input logic [N-1:0] bi);
    @(negedge clk);
    bcd = b; lt_n = lt; bi_n = bi;
    @(posedge clk); #2;
  endtask

  task automatic chk(input string tag, input int k, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s digit %0d: actual %h expected %h", tag, k, act, exp);
    end
  endtask

  task automatic chk_rbo(input string tag, input int k, input logic exp);
    checks++;
    if (rbo_n[k] !== exp) begin
      errors++;
      $display("FAIL %s rbo digit %0d: actual %b expected %b", tag, k, rbo_n[k], exp);
    end
  endtask

  // full expectation from the requirements
  task automatic chk_model(input string tag);
    logic run;
    run = 1'b1;
    for (int k = N-1; k >= 0; k--) begin
      logic [3:0] d;
      logic rip, rbi_low;
      logic [6:0] e;
      d = bcd[4*k +: 4];
      rbi_low = (k == 0) ? 1'b0 : run;
      rip = rbi_low && d == 0 && lt_n;
      run = rip;
      if (!bi_n[k])  e = 7'h7F;
      else if (!lt_n) e = 7'h00;
      else if (rip)  e = 7'h7F;
      else           e = glyph_n(d);
      chk(tag, k, seg_n[7*k +: 7], e);
      chk_rbo(tag, k, !rip);
    end
  endtask

  task automatic t_idle;
    drive('0, 1'b1, '1);
    chk_model("R9 idle");
    chk("R9", 0, seg_n[6:0], 7'h40);
  endtask

  task automatic t_glyphs;  // top digit nonzero so no ripple below
    for (int c = 0; c < 16; c++) begin
      drive({4'd8, 4'(c), 4'(c), 4'(c)}, 1'b1, '1);
      chk(c < 10 ? "R1" : "R2", 0, seg_n[6:0], c < 10 ? glyph_n(4'(c)) : 7'h7F);
      chk_model(c < 10 ? "R1 model" : "R2 model");
    end
  endtask

  task automatic t_lamp;
    drive(16'h0000, 1'b0, '1);
    for (int k = 0; k < N; k++) chk("R3", k, seg_n[7*k +: 7], 7'h00);
    chk_rbo("R6 lamp zero", N-1, 1'b1);
    drive(16'hF0A5, 1'b0, '1);
    chk_model("R3 mixed");
  endtask

  task automatic t_blank_in;
    drive(16'h1234, 1'b0, 4'b0101);
    chk("R4 over lamp", 1, seg_n[13:7], 7'h7F);
    chk("R10 lamp kept", 2, seg_n[20:14], 7'h00);
    drive(16'h0012, 1'b1, 4'b1011);
    chk("R10 rbo kept", 2, seg_n[20:14], 7'h7F);
    chk_rbo("R10", 2, 1'b0);
    chk("R4", 2, seg_n[20:14], 7'h7F);
    chk("R10 glyph", 1, seg_n[13:7], glyph_n(4'd1));
    chk_model("R10 model");
  endtask

  task automatic t_ripple;
    drive(16'h0007, 1'b1, '1);
    chk_rbo("R5", 3, 1'b0); chk_rbo("R5", 2, 1'b0); chk_rbo("R5", 1, 1'b0);
    chk("R5 dark", 2, seg_n[20:14], 7'h7F);
    chk("R7", 0, seg_n[6:0], glyph_n(4'd7));
    drive(16'h0500, 1'b1, '1);
    chk("R7 msd rbi low", 2, seg_n[20:14], glyph_n(4'd5));
    chk_rbo("R6 nonzero", 2, 1'b1);
    chk("R8 inner zero", 1, seg_n[13:7], glyph_n(4'd0));
    chk_model("R8 model");
    for (int v = 0; v < 4; v++) begin
      drive(16'h0001 << (4*v), 1'b1, '1);
      chk_model("R8 run");
    end
    drive(16'h9000, 1'b1, '1);
    chk("R8 trailing", 0, seg_n[6:0], glyph_n(4'd0));
    drive(16'h00B0, 1'b1, '1);
    chk_rbo("R6 non-bcd", 1, 1'b1);
    chk_model("R2 R8 model");
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bcd = '0; lt_n = 1'b1; bi_n = '1;
    t_idle();
    t_glyphs();
    t_lamp();
    t_blank_in();
    t_ripple();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule